// File: doc/BRIEF.md
# Edge-Counting Tally Register with Capture Latch

This block keeps a 16-bit running tally of transitions seen on an external, asynchronous event pin. The pin is brought into the clock domain by a two-stage synchronizer. An edge detector then turns the selected transition into a single increment. Software reaches the block through a byte-wide register port with an address, a write strobe, write data and combinational read data. One control byte sets the active edge, triggers a capture of the tally, opens the tally for presetting, and chooses between continuous and strobe-sampled operation. It also marks whether counting depends on main power.

Reads of the tally bytes never see the live counter. They see a capture latch that is loaded only when software asks for it, so the two bytes always belong to one value. In strobe-sampled mode the pin is looked at once per sampling period, which is derived from a slow timebase tick. That mode always counts rising transitions and keeps counting on backup power, whatever the polarity and power bits hold. The sampling period stops when the oscillator-enable input is low.

Top module: `edge_tally`

## Requirements
- R1: Each qualifying transition of `evt_in`, after the two-flop synchronizer, adds exactly one to the 16-bit live count.
- R2: Control bit 0 (address 0Dh) picks the edge: 0 counts high-to-low transitions and 1 counts low-to-high transitions. The other direction adds nothing.
- R3: Writing the control byte with bit 3 set copies the live count into the capture latch in that same clock cycle. Address 0Eh reads the latch's low byte and 0Fh its high byte, and the latch keeps its value until the next capture.
- R4: While control bit 2 is set, transitions are not counted. Writes to 0Eh and 0Fh load the low and high byte of the live count. While bit 2 is clear, writes to 0Eh/0Fh leave the count unchanged.
- R5: Control bit 1 selects strobe-sampled mode. The pin is sampled only on a strobe that fires once every POLL_DIV timebase ticks, and a low sample followed by a high sample adds one. In this mode rising-edge, backup-power operation applies regardless of bits 0 and 7.
- R6: While `osc_en` is low, no sampling strobe occurs and strobe-sampled mode adds nothing.
- R7: With control bit 7 set (and bit 1 clear), counting happens only while `main_pwr_ok` is high. With bit 7 clear, counting does not depend on `main_pwr_ok`.
- R8: The live count wraps from FFFFh to 0000h.
- R9: Reset clears the live count, the capture latch and the control byte. Address 0Dh reads back bits 7, 3, 2, 1 and 0 as written, with bits 6:4 reading 0. Unmapped addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| evt_in | input | 1 | Asynchronous event pin |
| osc_en | input | 1 | Timebase running; gates the sampling strobe |
| tb_tick | input | 1 | Slow timebase tick, one cycle wide |
| main_pwr_ok | input | 1 | Main supply present |

## Verification
The assertions check, on every cycle, the rules that hold between neighbouring registers. The count moves by at most one outside loads, wraps to zero, and stays frozen while preset access is open or while the power gate is closed. In sampled mode it moves only right after a strobe and never while the oscillator is off. The capture latch changes only on a capture write. Only the bench scenarios can show the behaviour that spans many cycles: that the chosen edge direction is the one counted, that a capture survives later events, that a preset value comes back intact, and that a sampled-mode event shows up within one sampling period.

// File: rtl/edge_tally_pkg.sv
package edge_tally_pkg;

  localparam int BIT_POL  = 0;
  localparam int BIT_POLL = 1;
  localparam int BIT_WEN  = 2;
  localparam int BIT_CAP  = 3;
  localparam int BIT_NV   = 7;

  typedef struct packed {
    logic nv;
    logic cap;
    logic wen;
    logic poll;
    logic pol;
  } ctl_t;

  function automatic ctl_t ctl_from_byte(input logic [7:0] b);
    ctl_t c;
    c.nv   = b[BIT_NV];
    c.cap  = b[BIT_CAP];
    c.wen  = b[BIT_WEN];
    c.poll = b[BIT_POLL];
    c.pol  = b[BIT_POL];
    return c;
  endfunction

  function automatic logic [7:0] ctl_to_byte(input ctl_t c);
    logic [7:0] b;
    b = 8'h00;
    b[BIT_NV]   = c.nv;
    b[BIT_CAP]  = c.cap;
    b[BIT_WEN]  = c.wen;
    b[BIT_POLL] = c.poll;
    b[BIT_POL]  = c.pol;
    return b;
  endfunction

  // Sampled mode overrides polarity (rising) and power mode (backup).
  function automatic logic eff_rising(input ctl_t c);
    return c.poll | c.pol;
  endfunction

  function automatic logic eff_needs_main(input ctl_t c);
    return c.nv & ~c.poll;
  endfunction

endpackage

// File: rtl/et_poll_tick.sv
module et_poll_tick #(
  parameter int POLL_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic osc_en,
  input  logic tb_tick,
  output logic strobe
);
  localparam int CW = (POLL_DIV > 2) ? $clog2(POLL_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(POLL_DIV - 1);

  logic [CW-1:0] tick_cnt;
  logic          advance;

  assign advance = enable & osc_en & tb_tick;
  assign strobe  = advance & (tick_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      tick_cnt <= '0;
    end else if (advance) begin
      tick_cnt <= (tick_cnt == LAST) ? '0 : tick_cnt + 1'b1;
    end
  end

  p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt <= LAST);

endmodule

// File: rtl/et_edge_sense.sv
module et_edge_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic poll_mode,
  input  logic poll_strobe,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   level;
  logic                   prev;
  logic                   sample_en;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-2:0], din};
  end

  assign level     = chain[SYNC_STAGES-1];
  assign sample_en = ~poll_mode | poll_strobe;

  // prev tracks level every cycle outside sampled mode, so entering
  // sampled mode starts from the current pin level.
  always_ff @(posedge clk) begin
    if (!rst_n)         prev <= 1'b0;
    else if (sample_en) prev <= level;
  end

  assign rise = sample_en & level & ~prev;
  assign fall = sample_en & ~level & prev;

  p_rise_fall_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));

  p_one_rise_per_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/et_count_core.sv
module et_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [7:0]       wdata,
  input  logic             cap,
  output logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] snap
);
  localparam int HI_W = CNT_W - 8;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
    end else if (ld_lo || ld_hi) begin
      if (ld_lo) live[7:0]       <= wdata;
      if (ld_hi) live[CNT_W-1:8] <= HI_W'(wdata);
    end else if (inc) begin
      live <= bump(live);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   snap <= '0;
    else if (cap) snap <= live;
  end

  p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_lo || ld_hi) |=> (live == $past(live)) || (live == $past(live) + 1'b1));

  p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_lo && !ld_hi && (live == '1)) |=> (live == '0));

  p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(snap));

endmodule

// File: rtl/edge_tally.sv
module edge_tally
  import edge_tally_pkg::*;
#(
  parameter int          CNT_W       = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int          POLL_DIV    = 128,
  parameter logic [7:0]  ADDR_CTL    = 8'h0D,
  parameter logic [7:0]  ADDR_LO     = 8'h0E,
  parameter logic [7:0]  ADDR_HI     = 8'h0F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       evt_in,
  input  logic       osc_en,
  input  logic       tb_tick,
  input  logic       main_pwr_ok
);
  ctl_t             ctl_q;
  logic             wr_ctl, ld_lo, ld_hi, ld_any, cap_pulse;
  logic             strobe, rise, fall, edge_hit, pwr_allow, inc;
  logic [CNT_W-1:0] live, snap;

  assign wr_ctl    = bus_we & (bus_addr == ADDR_CTL);
  assign cap_pulse = wr_ctl & bus_wdata[BIT_CAP];
  assign ld_lo     = bus_we & ctl_q.wen & (bus_addr == ADDR_LO);
  assign ld_hi     = bus_we & ctl_q.wen & (bus_addr == ADDR_HI);
  assign ld_any    = ld_lo | ld_hi;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= ctl_from_byte(bus_wdata);
  end

  et_poll_tick #(.POLL_DIV(POLL_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (ctl_q.poll),
    .osc_en  (osc_en),
    .tb_tick (tb_tick),
    .strobe  (strobe)
  );

  et_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk         (clk),
    .rst_n       (rst_n),
    .din         (evt_in),
    .poll_mode   (ctl_q.poll),
    .poll_strobe (strobe),
    .rise        (rise),
    .fall        (fall)
  );

  assign edge_hit  = eff_rising(ctl_q) ? rise : fall;
  assign pwr_allow = ~eff_needs_main(ctl_q) | main_pwr_ok;
  assign inc       = edge_hit & pwr_allow & ~ctl_q.wen;

  et_count_core #(.CNT_W(CNT_W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (inc),
    .ld_lo (ld_lo),
    .ld_hi (ld_hi),
    .wdata (bus_wdata),
    .cap   (cap_pulse),
    .live  (live),
    .snap  (snap)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == ADDR_CTL)     bus_rdata = ctl_to_byte(ctl_q);
    else if (bus_addr == ADDR_LO) bus_rdata = snap[7:0];
    else if (bus_addr == ADDR_HI) bus_rdata = 8'(snap[CNT_W-1:8]);
  end

  p_wen_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.wen && !ld_any) |=> $stable(live));

  p_main_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.nv && !ctl_q.poll && !main_pwr_ok && !ld_any) |=> $stable(live));

  p_poll_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.poll && !strobe && !ld_any) |=> $stable(live));

  p_poll_no_osc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.poll && !osc_en && !ld_any) |=> $stable(live));

  p_reset_clear_r9: assert property (@(posedge clk)
    !rst_n |=> (live == '0) && (snap == '0) && (ctl_q == '0));

endmodule

// File: tb/sim_edge_tally.sv
module sim_edge_tally;
  localparam int CLK_PERIOD = 10;
  localparam int POLL_DIV   = 4;
  localparam int TICK_DIV   = 3;
  localparam int SAMPLE_PER = POLL_DIV * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       evt_in = 1'b0;
  logic       osc_en = 1'b1;
  logic       tb_tick = 1'b0;
  logic       main_pwr_ok = 1'b1;

  int n_run = 0;
  int n_fail = 0;
  logic rd_req = 1'b0;
  logic [7:0] q_exp[$];
  string      q_req[$];
  int         mdl = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_tally #(.POLL_DIV(POLL_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .osc_en(osc_en), .tb_tick(tb_tick), .main_pwr_ok(main_pwr_ok)
  );

  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      tb_tick = (k % TICK_DIV) == 0;
      k++;
    end
  end

  // Monitor: pops expected items and compares against the read port.
  always @(negedge clk) begin
    if (rd_req && q_exp.size() > 0) begin
      logic [7:0] e;
      string r;
      e = q_exp.pop_front();
      r = q_req.pop_front();
      n_run++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s addr=%02h actual=%02h expected=%02h", r, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string r);
    @(posedge clk); #1;
    bus_addr = a;
    q_exp.push_back(e);
    q_req.push_back(r);
    rd_req = 1'b1;
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic pulse();
    evt_in = 1'b1; cyc(6);
    evt_in = 1'b0; cyc(6);
  endtask

  // Capture then check both bytes against the bench model.
  task automatic cap_check(input logic [7:0] ctl, input string r);
    wr(8'h0D, ctl | 8'h08);
    expect_rd(8'h0E, 8'(mdl & 16'hFFFF), r);
    expect_rd(8'h0F, 8'((mdl >> 8) & 8'hFF), r);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    // R9 reset state
    expect_rd(8'h0D, 8'h00, "R9 ctl after reset");
    expect_rd(8'h0E, 8'h00, "R9 lo after reset");
    expect_rd(8'h0F, 8'h00, "R9 hi after reset");
    expect_rd(8'h33, 8'h00, "R9 unmapped");

    // R1/R2 rising polarity
    wr(8'h0D, 8'h01);
    repeat (3) begin pulse(); mdl++; end
    cap_check(8'h01, "R1 R2 rising count");
    expect_rd(8'h0D, 8'h09, "R9 ctl readback");

    // R2 falling polarity: a rise alone adds nothing
    wr(8'h0D, 8'h00);
    evt_in = 1'b1; cyc(8);
    cap_check(8'h00, "R2 rise ignored when falling");
    evt_in = 1'b0; cyc(8); mdl++;
    cap_check(8'h00, "R2 falling counted");
    pulse(); mdl++;
    cap_check(8'h00, "R2 falling pulse");

    // R3 snapshot holds while live count advances
    wr(8'h0D, 8'h01);
    pulse(); mdl++;
    expect_rd(8'h0E, 8'(mdl - 1), "R3 snapshot stable");
    cap_check(8'h01, "R3 new capture");

    // R4 writes ignored with bit 2 clear
    wr(8'h0E, 8'h55);
    cap_check(8'h01, "R4 write ignored");

    // R4 blocking and preset
    wr(8'h0D, 8'h05);
    pulse(); pulse();
    wr(8'h0E, 8'hFE); wr(8'h0F, 8'hFF); mdl = 16'hFFFE;
    cap_check(8'h05, "R4 preset under write enable");
    wr(8'h0D, 8'h01);
    pulse(); mdl = 16'hFFFF;
    cap_check(8'h01, "R4 counting resumes");
    // R8 wrap
    pulse(); pulse(); mdl = 1;
    cap_check(8'h01, "R8 wrap to zero");

    // R7 main power gating
    wr(8'h0D, 8'h81);
    main_pwr_ok = 1'b0;
    pulse();
    cap_check(8'h81, "R7 blocked without main power");
    main_pwr_ok = 1'b1;
    pulse(); mdl++;
    cap_check(8'h81, "R7 counts with main power");
    wr(8'h0D, 8'h01);
    main_pwr_ok = 1'b0;
    pulse(); mdl++;
    cap_check(8'h01, "R7 backup counts");

    // R5 sampled mode, forced rising and backup power
    wr(8'h0D, 8'h82);
    cyc(30);
    evt_in = 1'b1; cyc(SAMPLE_PER * 3); mdl++;
    cap_check(8'h82, "R5 sampled rise counted");
    evt_in = 1'b0; cyc(SAMPLE_PER * 3);
    cap_check(8'h82, "R5 fall not counted");

    // R5 latency bounded by one sampling period
    begin
      int lat = -1;
      evt_in = 1'b1;
      for (int i = 0; i < SAMPLE_PER * 3 && lat < 0; i++) begin
        wr(8'h0D, 8'h8A);
        if (bus_addr == 8'h0D) bus_addr = 8'h0E;
        #1;
        if (bus_rdata == 8'(mdl + 1)) lat = 2 * (i + 1);
      end
      mdl++;
      n_run++;
      if (lat < 0 || lat > 2 * SAMPLE_PER + 8) begin
        n_fail++;
        $display("FAIL R5 sampling latency actual=%0d expected<=%0d", lat, 2 * SAMPLE_PER + 8);
      end
      evt_in = 1'b0; cyc(SAMPLE_PER * 3);
    end

    // R6 no samples with oscillator off
    osc_en = 1'b0;
    evt_in = 1'b1; cyc(40);
    evt_in = 1'b0; cyc(40);
    osc_en = 1'b1; cyc(SAMPLE_PER * 3);
    cap_check(8'h82, "R6 no sampling without osc");

    cyc(4);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule